// File: doc/BRIEF.md
# Checkpointed Register Rename Map Without Snapshot Copies

This block is the rename map of an out-of-order core. It renames one instruction per cycle, which has two source registers and one destination register. Each source architectural register becomes the physical register that holds its newest value, and the block also returns the mapping that the destination had before this instruction. The new physical register for the destination comes from an external free list. The map supports speculation. A checkpoint is not a copied snapshot. It is a fresh mapping table taken from a small ring of tables, and every speculative epoch writes only into its own table. Opening a checkpoint, recovering from a misprediction and releasing a checkpoint therefore only move two ring pointers.

One bit per architectural register and per table records whether that table holds a mapping for the register. A lookup selects the newest live table whose bit is set. If no live table has the bit set, the lookup falls back to a separate committed table, which the commit stage writes through its own port. All ring tables are stored in one flattened array, addressed by {table, register}. Both arrays have a single write port, and each is replicated three times to give three read ports with a registered read. A rename takes two stages. The first stage searches and updates the flags and forms the addresses. The second stage reads the arrays, selects the result and performs the array write. A write in stage 2 is forwarded to a dependent lookup in stage 1, and a commit write is forwarded to a lookup made in the same cycle.

Top module: `ckpt_rat`

## Requirements
- R1: After reset, every architectural register i maps to physical register i. Only one table is live, and ren_ready is high when no recovery is requested.
- R2: A rename accepted in cycle T (ren_valid and ren_ready high at the edge) raises out_valid in cycle T+1. In that cycle out_psrc1 and out_psrc2 carry the newest mapping of the sources, taken over all earlier accepted renames that recovery has not discarded. out_valid is low in every cycle that follows a cycle with no accepted rename.
- R3: out_pold is the mapping of ren_dst as it stood before this instruction. A source equal to the instruction's own destination also sees that older mapping. A rename with ren_dst_we low changes no mapping.
- R4: A source that names the destination of the rename accepted in the directly preceding cycle returns that rename's ren_new_preg.
- R5: A rename with ren_ckpt high first writes its own destination in the current epoch and then opens a new epoch. out_tag gives the index of the new table. Table indices count up by one modulo NUM_CKPT, starting from 0 at reset, so the first checkpoint gets tag 1.
- R6: When NUM_CKPT tables are live, a rename with ren_ckpt high is refused (ren_ready low), and the refused rename changes no state. ren_ready drops only for such a refusal or for a recovery.
- R7: rec_valid with rec_tag restores every mapping to its state just after the rename that was given that tag. A rename presented in the same cycle is refused.
- R8: cmt_we writes cmt_preg into the committed table at cmt_arch. A register held in no live table reads from the committed table, and that includes a commit made in the same cycle as the lookup.
- R9: cmt_ckpt releases the oldest live table. A checkpoint that was refused because the ring was full is accepted in the cycle after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename request can be accepted this cycle |
| ren_src1 | input | 5 | First source architectural register |
| ren_src2 | input | 5 | Second source architectural register |
| ren_dst | input | 5 | Destination architectural register |
| ren_dst_we | input | 1 | Instruction writes its destination |
| ren_new_preg | input | 6 | Physical register from the free list |
| ren_ckpt | input | 1 | Instruction opens a new epoch after itself |
| out_valid | output | 1 | Rename results valid (one cycle after acceptance) |
| out_psrc1 | output | 6 | Physical name of the first source |
| out_psrc2 | output | 6 | Physical name of the second source |
| out_pold | output | 6 | Previous mapping of the destination |
| out_tag | output | 2 | Table index opened by a checkpointing rename |
| cmt_we | input | 1 | Commit writes a mapping to the committed table |
| cmt_arch | input | 5 | Committing architectural register |
| cmt_preg | input | 6 | Committing physical register |
| cmt_ckpt | input | 1 | Committing instruction had opened a checkpoint |
| rec_valid | input | 1 | Misprediction recovery request |
| rec_tag | input | 2 | Table index to recover to |

## Verification
Two pairs of functions can fall in the same cycle: a rename lookup and a commit write, and a checkpoint request and a checkpoint release. Random traffic commits the oldest outstanding instruction while new renames are presented. Directed cases first fill the ring until a checkpoint is refused. They then release the oldest table in the cycle a new checkpoint is requested, which the bench expects to be refused, and expect acceptance one cycle later. Every returned mapping is compared with a bench model that keeps a plain current map, one saved copy per tag and an in-order queue of outstanding instructions. The model shares no structure with the flag search of the design.

// File: rtl/rat_pkg.sv
package rat_pkg;
   typedef enum logic [1:0] {
      SEL_RING   = 2'd0,
      SEL_COMMIT = 2'd1,
      SEL_BYPASS = 2'd2
   } rd_sel_e;

   localparam int LOOKUPS = 3;
endpackage

// File: rtl/rat_bank.sv
module rat_bank #(
   parameter int DEPTH     = 128,
   parameter int WIDTH     = 6,
   parameter int RD_PORTS  = 3,
   parameter bit INIT_ID   = 1'b0,
   parameter int AW        = $clog2(DEPTH)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [AW-1:0]                    waddr,
   input  logic [WIDTH-1:0]                 wdata,
   input  logic [RD_PORTS-1:0][AW-1:0]      raddr,
   output logic [RD_PORTS-1:0][WIDTH-1:0]   rdata
);
   initial begin : p_param_chk
      assert (DEPTH >= 2 && WIDTH >= 1 && RD_PORTS >= 1)
         else $fatal(1, "rat_bank: bad geometry");
   end

   for (genvar g = 0; g < RD_PORTS; g++) begin : g_copy
      logic [WIDTH-1:0] mem [DEPTH];

      if (INIT_ID) begin : g_reset_id
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= WIDTH'(i);
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) rdata[g] <= '0;
         else        rdata[g] <= mem[raddr[g]];
      end
   end
endmodule

// File: rtl/rat_newest.sv
module rat_newest #(
   parameter int NUM_CKPT = 4,
   parameter int CW       = $clog2(NUM_CKPT)
) (
   input  logic [NUM_CKPT-1:0] row,
   input  logic [CW-1:0]       head,
   input  logic [CW-1:0]       tail,
   output logic                hit,
   output logic [CW-1:0]       tab
);
   logic [CW-1:0] span;
   assign span = head - tail;

   // scan from the oldest live table to the newest; the last match wins
   always_comb begin
      hit = 1'b0;
      tab = head;
      for (int k = NUM_CKPT - 1; k >= 0; k--) begin
         if (CW'(k) <= span && row[head - CW'(k)]) begin
            hit = 1'b1;
            tab = head - CW'(k);
         end
      end
   end
endmodule

// File: rtl/ckpt_rat.sv
module ckpt_rat
   import rat_pkg::*;
#(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 64,
   parameter int NUM_CKPT = 4,
   parameter int AW       = $clog2(NUM_ARCH),
   parameter int PW       = $clog2(NUM_PHYS),
   parameter int CW       = $clog2(NUM_CKPT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ren_valid,
   output logic          ren_ready,
   input  logic [AW-1:0] ren_src1,
   input  logic [AW-1:0] ren_src2,
   input  logic [AW-1:0] ren_dst,
   input  logic          ren_dst_we,
   input  logic [PW-1:0] ren_new_preg,
   input  logic          ren_ckpt,
   output logic          out_valid,
   output logic [PW-1:0] out_psrc1,
   output logic [PW-1:0] out_psrc2,
   output logic [PW-1:0] out_pold,
   output logic [CW-1:0] out_tag,
   input  logic          cmt_we,
   input  logic [AW-1:0] cmt_arch,
   input  logic [PW-1:0] cmt_preg,
   input  logic          cmt_ckpt,
   input  logic          rec_valid,
   input  logic [CW-1:0] rec_tag
);
   localparam int FW         = CW + AW;
   localparam int RING_DEPTH = NUM_CKPT * NUM_ARCH;

   initial begin : p_param_chk
      assert (NUM_CKPT >= 2 && (NUM_CKPT & (NUM_CKPT - 1)) == 0)
         else $fatal(1, "ckpt_rat: NUM_CKPT must be a power of two >= 2");
      assert ((NUM_ARCH & (NUM_ARCH - 1)) == 0 && NUM_ARCH >= 2)
         else $fatal(1, "ckpt_rat: NUM_ARCH must be a power of two");
      assert (NUM_PHYS >= NUM_ARCH)
         else $fatal(1, "ckpt_rat: NUM_PHYS must cover the identity map");
   end

   // ---------------- epoch ring state ----------------
   logic [CW-1:0]       head_q, tail_q;
   logic [NUM_CKPT-1:0] dirty_q [NUM_ARCH];
   logic                ring_full, accept;

   assign ring_full = (head_q + CW'(1)) == tail_q;
   assign ren_ready = !rec_valid && !(ren_ckpt && ring_full);
   assign accept    = ren_valid && ren_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (rec_valid)                head_q <= rec_tag;
         else if (accept && ren_ckpt)  head_q <= head_q + CW'(1);
         if (cmt_ckpt)                 tail_q <= tail_q + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_ARCH; a++) dirty_q[a] <= '0;
      end else begin
         for (int a = 0; a < NUM_ARCH; a++) begin
            if (rec_valid)                dirty_q[a][rec_tag] <= 1'b0;
            else if (accept && ren_ckpt)  dirty_q[a][head_q + CW'(1)] <= 1'b0;
         end
         if (accept && ren_dst_we) dirty_q[ren_dst][head_q] <= 1'b1;
      end
   end

   // ---------------- stage 1: search and address forming ----------------
   logic [LOOKUPS-1:0][AW-1:0] areg;
   logic [LOOKUPS-1:0]         hit;
   logic [LOOKUPS-1:0][CW-1:0] tab;
   logic [LOOKUPS-1:0][FW-1:0] ring_ra;
   logic [LOOKUPS-1:0][AW-1:0] cmt_ra;
   rd_sel_e                    sel_d [LOOKUPS];
   logic [LOOKUPS-1:0][PW-1:0] byp_d;

   assign areg[0] = ren_src1;
   assign areg[1] = ren_src2;
   assign areg[2] = ren_dst;

   // stage-2 registers
   logic          s2_valid, s2_we;
   logic [FW-1:0] s2_widx;
   logic [PW-1:0] s2_newp;
   logic [CW-1:0] s2_tag;
   rd_sel_e       s2_sel [LOOKUPS];
   logic [LOOKUPS-1:0][PW-1:0] s2_byp;

   for (genvar p = 0; p < LOOKUPS; p++) begin : g_look
      rat_newest #(.NUM_CKPT(NUM_CKPT), .CW(CW)) u_find (
         .row  (dirty_q[areg[p]]),
         .head (head_q),
         .tail (tail_q),
         .hit  (hit[p]),
         .tab  (tab[p])
      );
      assign ring_ra[p] = {tab[p], areg[p]};
      assign cmt_ra[p]  = areg[p];

      always_comb begin
         sel_d[p] = hit[p] ? SEL_RING : SEL_COMMIT;
         byp_d[p] = cmt_preg;
         if (hit[p] && s2_valid && s2_we && s2_widx == ring_ra[p]) begin
            sel_d[p] = SEL_BYPASS;
            byp_d[p] = s2_newp;
         end else if (!hit[p] && cmt_we && cmt_arch == areg[p]) begin
            sel_d[p] = SEL_BYPASS;
            byp_d[p] = cmt_preg;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_we    <= 1'b0;
         s2_widx  <= '0;
         s2_newp  <= '0;
         s2_tag   <= '0;
         for (int p = 0; p < LOOKUPS; p++) s2_sel[p] <= SEL_COMMIT;
         s2_byp   <= '0;
      end else begin
         s2_valid <= accept;
         s2_we    <= accept && ren_dst_we;
         s2_widx  <= {head_q, ren_dst};
         s2_newp  <= ren_new_preg;
         s2_tag   <= head_q + CW'(1);
         for (int p = 0; p < LOOKUPS; p++) s2_sel[p] <= sel_d[p];
         s2_byp   <= byp_d;
      end
   end

   // ---------------- stage 2: arrays and selection ----------------
   logic [LOOKUPS-1:0][PW-1:0] ring_rd, cmt_rd, res;

   rat_bank #(.DEPTH(RING_DEPTH), .WIDTH(PW), .RD_PORTS(LOOKUPS),
              .INIT_ID(1'b0), .AW(FW)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (s2_valid && s2_we),
      .waddr (s2_widx),
      .wdata (s2_newp),
      .raddr (ring_ra),
      .rdata (ring_rd)
   );

   rat_bank #(.DEPTH(NUM_ARCH), .WIDTH(PW), .RD_PORTS(LOOKUPS),
              .INIT_ID(1'b1), .AW(AW)) u_commit (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cmt_we),
      .waddr (cmt_arch),
      .wdata (cmt_preg),
      .raddr (cmt_ra),
      .rdata (cmt_rd)
   );

   for (genvar p = 0; p < LOOKUPS; p++) begin : g_pick
      always_comb begin
         unique case (s2_sel[p])
            SEL_RING:   res[p] = ring_rd[p];
            SEL_COMMIT: res[p] = cmt_rd[p];
            default:    res[p] = s2_byp[p];
         endcase
      end
   end

   assign out_valid = s2_valid;
   assign out_psrc1 = res[0];
   assign out_psrc2 = res[1];
   assign out_pold  = res[2];
   assign out_tag   = s2_tag;
endmodule

// File: rtl/rat_chk.sv
module rat_chk #(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 64,
   parameter int NUM_CKPT = 4,
   parameter int AW       = $clog2(NUM_ARCH),
   parameter int PW       = $clog2(NUM_PHYS),
   parameter int CW       = $clog2(NUM_CKPT)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ren_valid,
   input logic          ren_ready,
   input logic [AW-1:0] ren_src1,
   input logic [AW-1:0] ren_dst,
   input logic          ren_dst_we,
   input logic [PW-1:0] ren_new_preg,
   input logic          ren_ckpt,
   input logic          rec_valid,
   input logic          out_valid,
   input logic [PW-1:0] out_psrc1,
   input logic [CW-1:0] out_tag,
   input logic [CW-1:0] head_q
);
   assert_out_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ren_valid && ren_ready |=> out_valid);

   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ren_valid && ren_ready) |=> !out_valid);

   assert_rec_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> !ren_ready);

   assert_ready_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ren_ready |-> (rec_valid || ren_ckpt));

   assert_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ren_valid && ren_ready && $past(ren_valid && ren_ready && ren_dst_we)
         && ren_src1 == $past(ren_dst)
      |=> out_psrc1 == $past(ren_new_preg, 2));

   assert_tag_is_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ren_valid && ren_ready && ren_ckpt |=> head_q == out_tag);
endmodule

bind ckpt_rat rat_chk #(
   .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_CKPT(NUM_CKPT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ren_valid    (ren_valid),
   .ren_ready    (ren_ready),
   .ren_src1     (ren_src1),
   .ren_dst      (ren_dst),
   .ren_dst_we   (ren_dst_we),
   .ren_new_preg (ren_new_preg),
   .ren_ckpt     (ren_ckpt),
   .rec_valid    (rec_valid),
   .out_valid    (out_valid),
   .out_psrc1    (out_psrc1),
   .out_tag      (out_tag),
   .head_q       (head_q)
);

// File: tb/sim_ckpt_rat.sv
`timescale 1ns/100ps
module sim_ckpt_rat;
   localparam int NA = 32;
   localparam int NP = 64;
   localparam int NC = 4;
   localparam int QD = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ren_valid = 1'b0, ren_dst_we = 1'b0, ren_ckpt = 1'b0;
   logic       ren_ready;
   logic [4:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
   logic [5:0] ren_new_preg = '0;
   logic       out_valid;
   logic [5:0] out_psrc1, out_psrc2, out_pold;
   logic [1:0] out_tag;
   logic       cmt_we = 1'b0, cmt_ckpt = 1'b0;
   logic [4:0] cmt_arch = '0;
   logic [5:0] cmt_preg = '0;
   logic       rec_valid = 1'b0;
   logic [1:0] rec_tag = '0;

   always #2.5 clk = ~clk;

   ckpt_rat #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_CKPT(NC)) u0 (.*);

   int errors = 0;
   int checks = 0;

   // reference model: plain current map, saved copy per tag, in-order queue
   int cur [NA];
   int snap [NC][NA];
   int mhead = 0;
   int oc = 0;
   int q_dst [QD], q_p [QD], q_tag [QD];
   bit q_we [QD], q_ck [QD];
   int qh = 0, qt = 0;

   bit    pend = 0, pend_ck = 0;
   int    e1, e2, eo, etag;
   string ptag;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic cycle(input bit rv, input int s1, input int s2, input int d,
                        input bit dwe, input int np, input bit ck,
                        input bit do_cmt, input bit rec, input int rtag,
                        input string tag);
      bit exp_ready, acc, took;
      int ci;
      @(negedge clk);
      if (pend) begin
         chk(out_valid == 1'b1, ptag, "out_valid", int'(out_valid), 1);
         chk(int'(out_psrc1) == e1, ptag, "out_psrc1", int'(out_psrc1), e1);
         chk(int'(out_psrc2) == e2, ptag, "out_psrc2", int'(out_psrc2), e2);
         chk(int'(out_pold) == eo, ptag, "out_pold", int'(out_pold), eo);
         if (pend_ck) chk(int'(out_tag) == etag, ptag, "out_tag", int'(out_tag), etag);
      end else begin
         chk(out_valid == 1'b0, "R2", "idle out_valid", int'(out_valid), 0);
      end
      pend = 0;
      took = do_cmt && !rec && (qt != qh);
      ci = qh % QD;
      ren_valid    = rv;
      ren_src1     = 5'(s1);
      ren_src2     = 5'(s2);
      ren_dst      = 5'(d);
      ren_dst_we   = dwe;
      ren_new_preg = 6'(np);
      ren_ckpt     = ck;
      cmt_we       = took && q_we[ci];
      cmt_arch     = 5'(q_dst[ci]);
      cmt_preg     = 6'(q_p[ci]);
      cmt_ckpt     = took && q_ck[ci];
      rec_valid    = rec;
      rec_tag      = 2'(rtag);
      #1;
      exp_ready = !rec && !(ck && oc == NC - 1);
      chk(ren_ready == exp_ready, ck && !rec ? "R6" : tag, "ren_ready",
          int'(ren_ready), int'(exp_ready));
      acc = rv && exp_ready;
      if (acc) begin
         e1 = cur[s1]; e2 = cur[s2]; eo = cur[d];
         if (dwe) cur[d] = np;
         if (ck) begin
            mhead = (mhead + 1) % NC;
            for (int a = 0; a < NA; a++) snap[mhead][a] = cur[a];
            oc++;
            etag = mhead;
         end
         q_dst[qt % QD] = d; q_p[qt % QD] = np; q_we[qt % QD] = dwe;
         q_ck[qt % QD] = ck; q_tag[qt % QD] = mhead;
         qt++;
         pend = 1; pend_ck = ck; ptag = tag;
      end
      if (took) begin
         if (q_ck[ci]) oc--;
         qh++;
      end
      if (rec) begin
         for (int a = 0; a < NA; a++) cur[a] = snap[rtag][a];
         mhead = rtag;
         for (int i = qh; i < qt; i++)
            if (q_ck[i % QD] && q_tag[i % QD] == rtag) begin
               qt = i + 1;
               break;
            end
         oc = 0;
         for (int i = qh; i < qt; i++) if (q_ck[i % QD]) oc++;
      end
   endtask

   function automatic int pick_tag(input int r);
      int n = 0, want;
      for (int i = qh; i < qt; i++) if (q_ck[i % QD]) n++;
      want = r % n;
      for (int i = qh; i < qt; i++)
         if (q_ck[i % QD]) begin
            if (want == 0) return q_tag[i % QD];
            want--;
         end
      return 0;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int seed;
      seed = 32'h5eed_0427;
      void'($urandom(seed));
      for (int a = 0; a < NA; a++) cur[a] = a;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: identity after reset, no destination write
      cycle(1, 7, 31, 0, 0, 0, 0, 0, 0, 0, "R1");
      cycle(1, 0, 19, 12, 0, 0, 0, 0, 0, 0, "R1");
      // R3: source equals own destination sees the old name
      cycle(1, 4, 4, 4, 1, 40, 0, 0, 0, 0, "R3");
      // R4: back-to-back dependence
      cycle(1, 4, 2, 9, 1, 33, 0, 0, 0, 0, "R4");
      cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
      cycle(1, 9, 4, 4, 0, 0, 0, 0, 0, 0, "R2");
      // R5: checkpoint writes first, then opens tag 1
      cycle(1, 4, 1, 4, 1, 41, 1, 0, 0, 0, "R5");
      cycle(1, 4, 1, 4, 1, 42, 0, 0, 0, 0, "R5");
      cycle(1, 4, 9, 9, 1, 43, 0, 0, 0, 0, "R5");
      // R7: recovery to tag 1, same-cycle rename refused
      cycle(1, 4, 9, 4, 1, 60, 0, 0, 1, 1, "R7");
      cycle(1, 4, 9, 4, 0, 0, 0, 0, 0, 0, "R7");
      // R6: fill the ring, then a refused checkpoint
      cycle(1, 3, 3, 3, 1, 50, 1, 0, 0, 0, "R6");
      cycle(1, 5, 5, 5, 1, 51, 1, 0, 0, 0, "R6");
      cycle(1, 6, 6, 6, 1, 52, 1, 0, 0, 0, "R6");
      cycle(1, 6, 5, 3, 1, 53, 0, 0, 0, 0, "R6");
      // R9: release in the same cycle as the request, then accepted next
      while (!q_ck[qh % QD]) cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9");
      cycle(1, 6, 3, 7, 1, 54, 1, 1, 0, 0, "R9");
      cycle(1, 6, 3, 7, 1, 54, 1, 0, 0, 0, "R9");
      // R8: drain, then a register only in the committed table
      while (qt != qh) cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
      cycle(1, 0, 0, 11, 1, 55, 0, 0, 0, 0, "R8");
      cycle(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
      cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
      cycle(1, 11, 0, 11, 0, 0, 0, 1, 0, 0, "R8");
      cycle(1, 11, 4, 11, 0, 0, 0, 0, 0, 0, "R8");

      // random traffic with overlapping commit and rename
      for (int n = 0; n < 4000; n++) begin
         bit rv, ck, cm, rc;
         int rt;
         rv = ($urandom % 4 != 0) && (qt - qh < QD - 8);
         ck = ($urandom % 5 == 0);
         cm = ($urandom % 3 != 0);
         rc = (oc > 0) && ($urandom % 23 == 0);
         rt = rc ? pick_tag(int'($urandom % 16)) : 0;
         cycle(rv, int'($urandom % NA), int'($urandom % NA), int'($urandom % NA),
               ($urandom % 8 != 0), int'($urandom % NP), ck, cm, rc, rt, "R2");
      end
      cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule